// File: doc/BRIEF.md
# Command Effects Log Engine

This block keeps a log that names every opcode a device supports, together with a mask of the side effects each one has. After reset it fills the log by itself. It walks the full 16-bit opcode space one opcode per cycle, in ascending order, and appends a 4-byte entry for each opcode found in a built-in command table. Until that walk is over, it accepts no requests.

Once the log is built, a requester can ask for one of two things. The first is the log size in bytes. The second is a byte slice of the log, given by a byte offset and a byte length. A slice request also carries a 128-bit identifier, which must equal the fixed identifier set by a parameter. A slice that passes both checks is streamed out one byte per cycle on a valid/ready byte stream, and a last flag marks its final byte. Every request gets a one-cycle response with a return code and a value.

Top module: `cel_engine`

## Requirements
- R1: From reset until the build walk ends (65536 cycles), `req_ready`, `rsp_valid` and `out_valid` stay low.
- R2: Log entries appear in ascending opcode order. Entry k occupies log bytes 4k..4k+3, holding the command byte (opcode low byte), the set byte (opcode high byte), the effect mask low byte and the effect mask high byte, in that order.
- R3: The log holds exactly one entry for each table opcode. The table, with each opcode's effect mask, is: 0x0100:0x00, 0x0101:0x10, 0x0102:0x00, 0x0103:0x02, 0x0200:0x00, 0x0300:0x00, 0x0301:0x08, 0x0400:0x00, 0x0401:0x00, 0x4000:0x00, 0x4100:0x00, 0x4102:0x00, 0x4103:0x06. Mask bits: bit 1 configuration change, bit 2 data change, bit 3 policy change, bit 4 log change.
- R4: A size request (`req_kind`=0) returns code 0x00 and a value of 4 times the entry count (52 with the default table), and streams no bytes.
- R5: A slice request (`req_kind`=1) that passes both checks returns code 0x00 with a value equal to the requested length. It then streams exactly that many bytes, starting at log byte `req_offset`, and asserts `out_last` on the last byte only.
- R6: A slice with offset + length greater than PAYLOAD_BYTES (256) is rejected with code 0x02 and value 0, and streams nothing. The sum is computed without wrap-around, and a sum of exactly 256 is accepted.
- R7: A slice whose `req_id` differs from LOG_ID is rejected with code 0x03 and value 0, and streams nothing.
- R8: When a slice fails both checks, the code is 0x02: the size check comes first.
- R9: Slice bytes that lie past the end of the log but inside the buffer read as 0x00.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R11: A slice of length 0 that passes both checks returns code 0x00 and value 0, and streams nothing.
- R12: `req_ready` is low while a slice is streaming. `rsp_valid` is high for exactly one cycle, the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and log built |
| req_kind | input | 1 | 0 = size request, 1 = slice request |
| req_id | input | 128 | Log identifier carried by a slice request |
| req_offset | input | 32 | Byte offset of the slice |
| req_length | input | 32 | Byte length of the slice |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 8 | Return code (0x00 ok, 0x02 bad range, 0x03 unknown log) |
| rsp_value | output | 32 | Log size, or accepted slice length |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the slice |

## Verification
The slice readout is tried with several requests. A full-log read shows entry order, byte lane order and effect masks together. An unaligned slice with a stalling sink shows that the offset is applied at byte granularity and that data holds under backpressure. A slice that runs past the log end separates real entries from zero fill. A set of range and identifier cases marks the accept/reject boundary: a sum of exactly 256 against 257, a huge offset that would wrap in 32 bits, a wrong identifier alone, and a wrong identifier with a bad range, which shows which check comes first. A size request and a zero-length slice show the paths that produce no stream.

// File: rtl/cel_pkg.sv
// Package: shared types, return codes and the built-in command table.
// Assumes 16-bit opcodes laid out as {set, command}.
package cel_pkg;

    localparam int OPC_W = 16;
    localparam int EFF_W = 16;

    // Side-effect mask bits
    localparam logic [EFF_W-1:0] EFF_CFG    = 16'h0002;
    localparam logic [EFF_W-1:0] EFF_DATA   = 16'h0004;
    localparam logic [EFF_W-1:0] EFF_POLICY = 16'h0008;
    localparam logic [EFF_W-1:0] EFF_LOG    = 16'h0010;

    // Return codes
    localparam logic [7:0] RC_OK        = 8'h00;
    localparam logic [7:0] RC_BAD_RANGE = 8'h02;
    localparam logic [7:0] RC_NO_LOG    = 8'h03;

    typedef struct packed {
        logic             hit;
        logic [EFF_W-1:0] eff;
    } tbl_hit_t;

    typedef enum logic { RD_IDLE = 1'b0, RD_STREAM = 1'b1 } rd_state_t;

    // Command table lookup: reports whether an opcode is supported and its effects.
    function automatic tbl_hit_t cmd_lookup(input logic [OPC_W-1:0] opc);
        tbl_hit_t r;
        r.hit = 1'b1;
        r.eff = '0;
        case (opc)
            16'h0100, 16'h0102, 16'h0200, 16'h0300,
            16'h0400, 16'h0401, 16'h4000, 16'h4100,
            16'h4102: r.eff = '0;
            16'h0101: r.eff = EFF_LOG;
            16'h0103: r.eff = EFF_CFG;
            16'h0301: r.eff = EFF_POLICY;
            16'h4103: r.eff = EFF_CFG | EFF_DATA;
            default:  r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cel_builder.sv
// Builder: after reset, walks every opcode once in ascending order and emits
// a write for each opcode found in the command table.
// Assumes the store has room for MAX_ENTRIES; extra hits are dropped.
module cel_builder
    import cel_pkg::*;
#(
    parameter int MAX_ENTRIES = 16,
    localparam int IDX_W = $clog2(MAX_ENTRIES),
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_data,
    output logic [CNT_W-1:0] entry_cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENTRIES);

    logic [OPC_W-1:0] opc;
    tbl_hit_t         look;

    // Table probe for the opcode under scan
    always_comb look = cmd_lookup(opc);

    assign wr_en   = !done && look.hit && (entry_cnt < CNT_MAX);
    assign wr_idx  = entry_cnt[IDX_W-1:0];
    assign wr_data = {look.eff, opc};

    // Scan counter, entry counter and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc       <= '0;
            entry_cnt <= '0;
            done      <= 1'b0;
        end else if (!done) begin
            if (wr_en) entry_cnt <= entry_cnt + 1'b1;
            if (opc == {OPC_W{1'b1}}) done <= 1'b1;
            else                      opc  <= opc + 1'b1;
        end
    end

    // Checker state: last opcode written, for the ordering property
    logic [OPC_W-1:0] prev_opc;
    logic             seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_opc <= '0;
            seen     <= 1'b0;
        end else if (wr_en) begin
            prev_opc <= opc;
            seen     <= 1'b1;
        end
    end

    // R2: entries are written in strictly ascending opcode order
    p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen) |-> (wr_data[OPC_W-1:0] > prev_opc));

    // R3: the entry count never exceeds capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_cnt <= CNT_MAX);

endmodule

// File: rtl/cel_store.sv
// Store: holds log entries as 32-bit words and serves one byte per address.
// Assumes byte lane order {cmd, set, eff_lo, eff_hi}; out-of-log bytes are zero.
module cel_store #(
    parameter int MAX_ENTRIES = 16,
    localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      rd_addr,
    output logic [7:0]       rd_byte
);
    logic [31:0] mem [MAX_ENTRIES];

    for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_ent
        // One entry register, cleared at reset, loaded on its own index
        always_ff @(posedge clk) begin
            if (!rst_n)                                  mem[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))        mem[g] <= wr_data;
        end
    end

    logic [29:0] word_sel;
    logic        in_log;
    logic [31:0] word;

    // Byte fetch with zero fill beyond the entry storage
    always_comb begin
        word_sel = rd_addr[31:2];
        in_log   = word_sel < 30'(MAX_ENTRIES);
        word     = in_log ? mem[word_sel[IDX_W-1:0]] : 32'h0;
        rd_byte  = word[8*rd_addr[1:0] +: 8];
    end

endmodule

// File: rtl/cel_reader.sv
// Reader: takes size and slice requests, checks range then identifier,
// answers with a one-cycle response and streams accepted slices bytewise.
// Assumes the store read is combinational on rd_addr.
module cel_reader
    import cel_pkg::*;
#(
    parameter int           MAX_ENTRIES   = 16,
    parameter int           PAYLOAD_BYTES = 256,
    parameter logic [127:0] LOG_ID        = 128'h0,
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             built,
    input  logic [CNT_W-1:0] entry_cnt,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_kind,
    input  logic [127:0]     req_id,
    input  logic [31:0]      req_offset,
    input  logic [31:0]      req_length,
    output logic             rsp_valid,
    output logic [7:0]       rsp_code,
    output logic [31:0]      rsp_value,
    output logic [31:0]      rd_addr,
    input  logic [7:0]       rd_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last
);
    localparam logic [32:0] LIMIT = 33'(PAYLOAD_BYTES);

    rd_state_t   state;
    logic [31:0] ptr;
    logic [31:0] remain;
    logic        take;
    logic        too_big;
    logic        id_bad;
    logic [7:0]  code_n;
    logic [31:0] value_n;

    assign req_ready = built && (state == RD_IDLE);
    assign take      = req_valid && req_ready;

    // Request evaluation: range first, then identifier
    always_comb begin
        too_big = ({1'b0, req_offset} + {1'b0, req_length}) > LIMIT;
        id_bad  = req_id != LOG_ID;
        if (!req_kind) begin
            code_n  = RC_OK;
            value_n = {{(30-CNT_W){1'b0}}, entry_cnt, 2'b00};
        end else if (too_big) begin
            code_n  = RC_BAD_RANGE;
            value_n = '0;
        end else if (id_bad) begin
            code_n  = RC_NO_LOG;
            value_n = '0;
        end else begin
            code_n  = RC_OK;
            value_n = req_length;
        end
    end

    // Response strobe and registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_value <= '0;
        end else begin
            rsp_valid <= take;
            if (take) begin
                rsp_code  <= code_n;
                rsp_value <= value_n;
            end
        end
    end

    // Stream state machine: pointer and remaining byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            ptr    <= '0;
            remain <= '0;
        end else if (state == RD_IDLE) begin
            if (take && req_kind && code_n == RC_OK && req_length != 0) begin
                state  <= RD_STREAM;
                ptr    <= req_offset;
                remain <= req_length;
            end
        end else if (out_ready) begin
            ptr    <= ptr + 1'b1;
            remain <= remain - 1'b1;
            if (remain == 32'd1) state <= RD_IDLE;
        end
    end

    assign rd_addr   = ptr;
    assign out_valid = (state == RD_STREAM);
    assign out_data  = rd_byte;
    assign out_last  = out_valid && (remain == 32'd1);

    // R10: stalled byte holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R12: no request accepted while streaming
    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R12: response strobe lasts one cycle
    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: a rejected request never streams
    p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != RC_OK) |-> !out_valid);

    // R5: a stream never reads beyond the buffer
    p_in_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, ptr} < LIMIT));

endmodule

// File: rtl/cel_engine.sv
// Top: command effects log engine. Builds the log after reset, then serves
// size and slice requests onto a byte stream.
// Assumes requests are held stable while req_valid is high.
module cel_engine #(
    parameter int           MAX_ENTRIES   = 16,
    parameter int           PAYLOAD_BYTES = 256,
    parameter logic [127:0] LOG_ID        = 128'h7e21_94ac_05d3_4b1f_a86e_c2f0_3917_d54b
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic         req_kind,
    input  logic [127:0] req_id,
    input  logic [31:0]  req_offset,
    input  logic [31:0]  req_length,
    output logic         rsp_valid,
    output logic [7:0]   rsp_code,
    output logic [31:0]  rsp_value,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [7:0]   out_data,
    output logic         out_last
);
    localparam int IDX_W = $clog2(MAX_ENTRIES);
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0]      wr_data;
    logic [CNT_W-1:0] entry_cnt;
    logic             built;
    logic [31:0]      rd_addr;
    logic [7:0]       rd_byte;

    cel_builder #(.MAX_ENTRIES(MAX_ENTRIES)) u_build (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .entry_cnt(entry_cnt), .done(built)
    );

    cel_store #(.MAX_ENTRIES(MAX_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_byte(rd_byte)
    );

    cel_reader #(
        .MAX_ENTRIES(MAX_ENTRIES), .PAYLOAD_BYTES(PAYLOAD_BYTES), .LOG_ID(LOG_ID)
    ) u_read (
        .clk(clk), .rst_n(rst_n), .built(built), .entry_cnt(entry_cnt),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_id(req_id), .req_offset(req_offset), .req_length(req_length),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_value(rsp_value),
        .rd_addr(rd_addr), .rd_byte(rd_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    // R1: nothing is accepted or emitted before the log is built
    p_quiet_build_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !built |-> (!req_ready && !out_valid && !rsp_valid));

endmodule

// File: tb/sim_cel_engine.sv
`timescale 1ns/1ps
module sim_cel_engine;
    localparam logic [127:0] ID_OK  = 128'h7e21_94ac_05d3_4b1f_a86e_c2f0_3917_d54b;
    localparam logic [127:0] ID_BAD = 128'h7e21_94ac_05d3_4b1f_a86e_c2f0_3917_d54c;
    localparam int NENT = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_kind = 1'b0;
    logic [127:0] req_id = '0;
    logic [31:0]  req_offset = '0;
    logic [31:0]  req_length = '0;
    logic         rsp_valid;
    logic [7:0]   rsp_code;
    logic [31:0]  rsp_value;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_data;
    logic         out_last;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] t_opc [NENT];
    logic [15:0] t_eff [NENT];

    always #10 clk = ~clk;

    cel_engine u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_id(req_id), .req_offset(req_offset),
        .req_length(req_length), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_value(rsp_value), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input logic ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input longint b);
        logic [31:0] w;
        if (b / 4 >= NENT) return 8'h00;
        w = {t_eff[b/4], t_opc[b/4]};
        return w[8*(b%4) +: 8];
    endfunction

    // R1: quiet during build, ready afterwards
    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!req_ready, "R1 req_ready during build", req_ready, 0);
        check(!out_valid && !rsp_valid, "R1 outputs during build", {out_valid, rsp_valid}, 0);
        repeat (65600) @(negedge clk);
        check(req_ready, "R1 req_ready after build", req_ready, 1);
    endtask

    // R4: size report
    task automatic t_size;
        @(negedge clk);
        req_kind = 1'b0; req_valid = 1'b1;
        check(req_ready, "R4 ready", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid, "R4 rsp_valid", rsp_valid, 1);
        check(rsp_code == 8'h00, "R4 code", rsp_code, 0);
        check(rsp_value == 32'd52, "R4 size", rsp_value, 52);
        check(!out_valid, "R4 no stream", out_valid, 0);
        @(negedge clk);
        check(!rsp_valid, "R12 rsp pulse", rsp_valid, 0);
    endtask

    // R5 R6 R7 R8 R9 R10 R11 R12: slice request with its own expected stream
    task automatic t_read(input logic [127:0] id, input logic [31:0] off, input logic [31:0] len,
                          input logic [7:0] ecode, input bit stall, input string tag);
        logic [31:0] evalue;
        evalue = (ecode == 8'h00) ? len : 32'd0;
        @(negedge clk);
        req_kind = 1'b1; req_id = id; req_offset = off; req_length = len; req_valid = 1'b1;
        check(req_ready, {tag, " ready"}, req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid, {tag, " rsp_valid"}, rsp_valid, 1);
        check(rsp_code == ecode, {tag, " code"}, rsp_code, ecode);
        check(rsp_value == evalue, {tag, " value"}, rsp_value, evalue);
        if (ecode == 8'h00 && len != 0) begin
            for (int i = 0; i < int'(len); i++) begin
                logic [7:0] eb;
                eb = exp_byte(longint'(off) + i);
                check(out_valid, {tag, " out_valid"}, out_valid, 1);
                if (i == 0) check(!req_ready, "R12 busy while streaming", req_ready, 0);
                if (stall && (i % 2 == 1)) begin
                    @(negedge clk);
                    check(out_valid && out_data == eb, "R10 hold under stall", out_data, eb);
                end
                check(out_data == eb, $sformatf("%s byte %0d", tag, i), out_data, eb);
                check(out_last == (i == int'(len) - 1), $sformatf("%s last %0d", tag, i),
                      out_last, (i == int'(len) - 1));
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
        end
        check(!out_valid, {tag, " stream ended"}, out_valid, 0);
        check(req_ready, {tag, " idle again"}, req_ready, 1);
    endtask

    initial begin
        t_opc = '{16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200, 16'h0300, 16'h0301,
                  16'h0400, 16'h0401, 16'h4000, 16'h4100, 16'h4102, 16'h4103};
        t_eff = '{16'h00, 16'h10, 16'h00, 16'h02, 16'h00, 16'h00, 16'h08,
                  16'h00, 16'h00, 16'h00, 16'h00, 16'h00, 16'h06};
        t_reset();
        t_size();
        t_read(ID_OK, 32'd0, 32'd52, 8'h00, 1'b0, "R2 R3 R5 full log");
        t_read(ID_OK, 32'd5, 32'd7, 8'h00, 1'b1, "R5 unaligned slice");
        t_read(ID_OK, 32'd48, 32'd12, 8'h00, 1'b0, "R9 past log end");
        t_read(ID_OK, 32'd200, 32'd56, 8'h00, 1'b0, "R6 exact fit");
        t_read(ID_OK, 32'd200, 32'd57, 8'h02, 1'b0, "R6 one over");
        t_read(ID_OK, 32'hFFFF_FFFF, 32'd2, 8'h02, 1'b0, "R6 no wrap");
        t_read(ID_BAD, 32'd0, 32'd4, 8'h03, 1'b0, "R7 wrong id");
        t_read(ID_BAD, 32'd250, 32'd10, 8'h02, 1'b0, "R8 range before id");
        t_read(ID_OK, 32'd8, 32'd0, 8'h00, 1'b0, "R11 zero length");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #3000000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule